// File: doc/BRIEF.md
# Ping-Pong Filter Coefficient Store

This block holds two banks of filter coefficients and lets a host rewrite one bank while the filter datapath keeps reading the other. The host sees a byte-wide, paged register space. Register 0 of every page selects the page. One page, the configuration page, carries a mode/status register and a window of coefficient byte registers.

Adaptive mode is enabled through the mode register. In that mode a swap request makes the two banks exchange roles on the next frame-boundary pulse, and the request bit then clears itself. The datapath therefore switches coefficient sets only between frames. When adaptive mode is off, the datapath uses bank A and the host may reach the coefficients only while the channel is powered down.

Each coefficient is assembled from consecutive byte registers, most significant byte first. It is written into its bank in one step when its last byte arrives, so the datapath never reads a half-updated coefficient.

Top module: `coef_pingpong_ctrl`

## Requirements
- R1: Register 0 on every page is a read/write page-select register. It resets to 0x00, accepts any value 0 to 255, and selects the page used by every later access.
- R2: Register 1 of the configuration page (`CFG_PAGE`, default 3) is the mode register, and it resets to 0x00. Bit 2 is the read/write adaptive enable. Bits 7..3 always read 0, whatever is written to them.
- R3: Bit 1 of the mode register is a read-only active-bank flag. When it is 0, the datapath reads bank A and the host reaches bank B. When it is 1, the datapath reads bank B and the host reaches bank A.
- R4: Bit 0 of the mode register is a swap request. If it is written as 1 while adaptive mode is on, the banks exchange roles on the next `frame_i` pulse and bit 0 clears at the same edge. Without a pulse, the roles do not change.
- R5: A swap request written in the same cycle as a `frame_i` pulse is not taken on that pulse. It is held and taken on the following pulse.
- R6: A swap request written while adaptive mode is off (bit 2 of the same write is 0) has no effect: bit 0 reads 0 and the flag stays 0 across later frame pulses.
- R7: While adaptive mode is off, the datapath reads bank A and the flag reads 0. This also holds right after adaptive mode is turned off while bank B was active.
- R8: With adaptive mode off and `pwr_down_i` low, host writes to coefficient registers are ignored and host reads of them return 0x00. When either condition lifts, access is allowed. With adaptive mode off, the host reaches bank A.
- R9: Coefficient k occupies registers 8+3k, 9+3k and 10+3k of the configuration page, most significant byte first. Reads return the bytes of the bank currently reached by the host.
- R10: A coefficient is written into its bank only when its least significant byte is written. The datapath value is unchanged after only the upper two bytes have been written.
- R11: All other registers (any register other than 0 on other pages, and registers 2..7 and those past the last coefficient on the configuration page) read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 7 | Register index within the current page |
| reg_wdata_i | input | 8 | Host write data |
| reg_we_i | input | 1 | Host write strobe, one cycle per byte |
| reg_rdata_o | output | 8 | Host read data for `reg_addr_i`, combinational |
| pwr_down_i | input | 1 | Channel powered-down status |
| frame_i | input | 1 | Frame-boundary pulse, one cycle wide |
| dp_addr_i | input | IDX_W (3) | Datapath coefficient index |
| dp_coef_o | output | COEF_W (24) | Datapath coefficient from the active bank, combinational |

## Verification
The swap logic is driven with three patterns:
- A request followed by idle cycles and then a pulse. This separates a swap committed at the boundary from one that takes effect at once.
- A request written in the same cycle as a pulse. This shows whether the request is deferred or taken early.
- A request written with adaptive mode off. This shows whether the request is correctly ignored.

Coefficient writes are driven with three patterns:
- Blocked writes, which show whether gating applies.
- Partial byte sequences, which show whether the update is atomic.
- Writes into the inactive bank followed by a datapath read, which show whether the host and datapath banks are kept apart.

// File: rtl/coef_pp_pkg.sv
package coef_pp_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] REG_PAGE  = 7'd0;
  localparam logic [ADDR_W-1:0] REG_MODE  = 7'd1;
  localparam logic [ADDR_W-1:0] COEF_BASE = 7'd8;

  localparam int BIT_EN  = 2;
  localparam int BIT_ACT = 1;
  localparam int BIT_REQ = 0;
endpackage

// File: rtl/coef_pp_regs.sv
module coef_pp_regs
  import coef_pp_pkg::*;
#(
  parameter logic [DATA_W-1:0] CFG_PAGE = 8'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              frame_i,
  output logic [DATA_W-1:0] page_o,
  output logic              cfg_sel_o,
  output logic              adapt_o,
  output logic              active_o,
  output logic              req_o
);
  logic [DATA_W-1:0] page_q;
  logic adapt_q, active_q, req_q;
  logic cfg_we, commit, adapt_d, active_d, req_d;

  assign cfg_sel_o = (page_q == CFG_PAGE);
  assign cfg_we    = we_i && cfg_sel_o && (addr_i == REG_MODE);
  assign commit    = frame_i && req_q && adapt_q;

  always_comb begin
    adapt_d  = cfg_we ? wdata_i[BIT_EN] : adapt_q;
    req_d    = req_q;
    active_d = active_q;
    if (cfg_we)      req_d = wdata_i[BIT_REQ] & wdata_i[BIT_EN];
    else if (commit) req_d = 1'b0;
    if (!adapt_d)    active_d = 1'b0;
    else if (commit) active_d = ~active_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q   <= '0;
      adapt_q  <= 1'b0;
      active_q <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      if (we_i && addr_i == REG_PAGE) page_q <= wdata_i;
      adapt_q  <= adapt_d;
      active_q <= active_d;
      req_q    <= req_d;
    end
  end

  assign page_o   = page_q;
  assign adapt_o  = adapt_q;
  assign active_o = active_q;
  assign req_o    = req_q;

  // R1
  page_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_PAGE) |=> page_q == $past(wdata_i));
  // R4
  swap_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && req_q && adapt_q && !cfg_we) |=> (active_q != $past(active_q)) && !req_q);
  // R4
  no_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_i && !cfg_we) |=> $stable(active_q));
  // R7
  flag_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adapt_q |-> !active_q);
  // R6
  req_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adapt_q |-> !req_q);
endmodule

// File: rtl/coef_pp_hostif.sv
module coef_pp_hostif
  import coef_pp_pkg::*;
#(
  parameter int NUM_COEF = 8,
  parameter int COEF_W   = 24,
  localparam int NB      = COEF_W / 8,
  localparam int IDX_W   = (NUM_COEF > 1) ? $clog2(NUM_COEF) : 1,
  localparam int BSEL_W  = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic              is_coef_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BSEL_W-1:0] bsel_o,
  output logic              commit_o,
  output logic [COEF_W-1:0] commit_data_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(int'(COEF_BASE) + NUM_COEF * NB - 1);

  logic [ADDR_W-1:0] off, quo, rem;
  logic [NB-2:0][7:0] stage_q;

  assign off       = addr_i - COEF_BASE;
  assign quo       = off / ADDR_W'(NB);
  assign rem       = off % ADDR_W'(NB);
  assign is_coef_o = (addr_i >= COEF_BASE) && (addr_i <= LAST);
  assign idx_o     = quo[IDX_W-1:0];
  assign bsel_o    = rem[BSEL_W-1:0];

  // last byte completes the word
  assign commit_o      = we_i && is_coef_o && (bsel_o == BSEL_W'(NB - 1));
  assign commit_data_o = {stage_q, wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (we_i && is_coef_o) begin
      for (int b = 0; b < NB - 1; b++)
        if (bsel_o == BSEL_W'(b)) stage_q[NB-2-b] <= wdata_i;
    end
  end
endmodule

// File: rtl/coef_pp_bank.sv
module coef_pp_bank #(
  parameter int NUM_COEF = 8,
  parameter int COEF_W   = 24,
  localparam int IDX_W   = (NUM_COEF > 1) ? $clog2(NUM_COEF) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_bank_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [COEF_W-1:0] wr_data_i,
  input  logic              h_bank_i,
  input  logic [IDX_W-1:0]  h_idx_i,
  output logic [COEF_W-1:0] h_data_o,
  input  logic              dp_bank_i,
  input  logic [IDX_W-1:0]  dp_idx_i,
  output logic [COEF_W-1:0] dp_data_o
);
  logic [COEF_W-1:0] mem_q [2][NUM_COEF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NUM_COEF; i++) mem_q[b][i] <= '0;
    end else if (wr_en_i && int'(wr_idx_i) < NUM_COEF) begin
      mem_q[wr_bank_i][wr_idx_i] <= wr_data_i;
    end
  end

  assign h_data_o  = (int'(h_idx_i)  < NUM_COEF) ? mem_q[h_bank_i][h_idx_i]   : '0;
  assign dp_data_o = (int'(dp_idx_i) < NUM_COEF) ? mem_q[dp_bank_i][dp_idx_i] : '0;
endmodule

// File: rtl/coef_pingpong_ctrl.sv
module coef_pingpong_ctrl
  import coef_pp_pkg::*;
#(
  parameter int NUM_COEF             = 8,
  parameter int COEF_W               = 24,
  parameter logic [DATA_W-1:0] CFG_PAGE = 8'd3,
  localparam int IDX_W               = (NUM_COEF > 1) ? $clog2(NUM_COEF) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [6:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              reg_we_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              pwr_down_i,
  input  logic              frame_i,
  input  logic [IDX_W-1:0]  dp_addr_i,
  output logic [COEF_W-1:0] dp_coef_o
);
  localparam int NB     = COEF_W / 8;
  localparam int BSEL_W = $clog2(NB);

  logic [DATA_W-1:0] page;
  logic cfg_sel, adapt, active, req;
  logic access_ok, coef_we, is_coef, commit;
  logic [IDX_W-1:0]  h_idx;
  logic [BSEL_W-1:0] bsel;
  logic [COEF_W-1:0] commit_data, h_word;
  logic h_bank, dp_bank;
  logic [7:0] h_byte;

  coef_pp_regs #(.CFG_PAGE(CFG_PAGE)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .we_i(reg_we_i), .frame_i,
    .page_o(page), .cfg_sel_o(cfg_sel), .adapt_o(adapt), .active_o(active), .req_o(req)
  );

  assign access_ok = adapt || pwr_down_i;
  assign coef_we   = reg_we_i && cfg_sel && access_ok;

  coef_pp_hostif #(.NUM_COEF(NUM_COEF), .COEF_W(COEF_W)) u_hostif (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .we_i(coef_we),
    .is_coef_o(is_coef), .idx_o(h_idx), .bsel_o(bsel),
    .commit_o(commit), .commit_data_o(commit_data)
  );

  // bank A = 0; non-adaptive: both sides on A
  assign dp_bank = adapt & active;
  assign h_bank  = adapt & ~active;

  coef_pp_bank #(.NUM_COEF(NUM_COEF), .COEF_W(COEF_W)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(commit), .wr_bank_i(h_bank), .wr_idx_i(h_idx), .wr_data_i(commit_data),
    .h_bank_i(h_bank), .h_idx_i(h_idx), .h_data_o(h_word),
    .dp_bank_i(dp_bank), .dp_idx_i(dp_addr_i), .dp_data_o(dp_coef_o)
  );

  always_comb begin
    h_byte = '0;
    for (int b = 0; b < NB; b++)
      if (bsel == BSEL_W'(b)) h_byte = h_word[(NB-1-b)*8 +: 8];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == REG_PAGE) begin
      reg_rdata_o = page;
    end else if (cfg_sel) begin
      if (reg_addr_i == REG_MODE) begin
        reg_rdata_o[BIT_EN]  = adapt;
        reg_rdata_o[BIT_ACT] = active;
        reg_rdata_o[BIT_REQ] = req;
      end else if (is_coef && access_ok) begin
        reg_rdata_o = h_byte;
      end
    end
  end

  // R8
  gate_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adapt && !pwr_down_i) |-> !commit);
  // R8
  gate_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adapt && !pwr_down_i && reg_addr_i != REG_PAGE) |-> reg_rdata_o == 8'h00);
endmodule

// File: tb/coef_pingpong_ctrl_bench.sv
module coef_pingpong_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic we = 1'b0;
  logic [7:0] rdata;
  logic pwr = 1'b0;
  logic frame = 1'b0;
  logic [2:0] dp_addr = '0;
  logic [23:0] dp_coef;
  int checks = 0;
  int fails = 0;
  logic [7:0] r;

  localparam logic [7:0] CFGP = 8'd3;

  always #5 clk = ~clk;

  coef_pingpong_ctrl u_coef_pingpong_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_we_i(we), .reg_rdata_o(rdata),
    .pwr_down_i(pwr), .frame_i(frame), .dp_addr_i(dp_addr), .dp_coef_o(dp_coef)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic dp(input logic [2:0] i, output logic [23:0] c);
    dp_addr = i; #1 c = dp_coef;
  endtask

  task automatic pulse();
    @(negedge clk); frame = 1'b1;
    @(negedge clk); frame = 1'b0;
  endtask

  task automatic wr_coef(input int k, input logic [23:0] v);
    wr(7'(8 + 3*k), v[23:16]);
    wr(7'(9 + 3*k), v[15:8]);
    wr(7'(10 + 3*k), v[7:0]);
  endtask

  task automatic t_reset_page();
    rd(7'd0, r); chk("R1 page reset", r, 8'h00);
    rd(7'd1, r); chk("R11 reserved on page 0", r, 8'h00);
    wr(7'd0, 8'hA5); rd(7'd0, r); chk("R1 page readback", r, 8'hA5);
    wr(7'd1, 8'hFF); rd(7'd1, r); chk("R11 reserved write ignored", r, 8'h00);
    wr(7'd0, CFGP); rd(7'd0, r); chk("R1 select cfg page", r, CFGP);
    rd(7'd1, r); chk("R2 mode reset", r, 8'h00);
  endtask

  task automatic t_gating();
    logic [23:0] c;
    pwr = 1'b0;
    wr_coef(0, 24'h123456);
    dp(3'd0, c); chk("R8 blocked write", c, 24'h0);
    pwr = 1'b1;
    wr(7'd8, 8'h12); wr(7'd9, 8'h34);
    pwr = 1'b0;
    rd(7'd8, r); chk("R8 blocked read", r, 8'h00);
    pwr = 1'b1;
    dp(3'd0, c); chk("R10 partial not visible", c, 24'h0);
    wr(7'd10, 8'h56);
    dp(3'd0, c); chk("R10 committed on LSB, R8 bank A", c, 24'h123456);
    rd(7'd8, r);  chk("R9 byte MSB", r, 8'h12);
    rd(7'd9, r);  chk("R9 byte mid", r, 8'h34);
    rd(7'd10, r); chk("R9 byte LSB", r, 8'h56);
    wr_coef(7, 24'h7A7B7C);
    dp(3'd7, c); chk("R9 last coefficient", c, 24'h7A7B7C);
    wr(7'd32, 8'hFF); rd(7'd32, r); chk("R11 past last coef", r, 8'h00);
    wr(7'd3, 8'hFF); rd(7'd3, r); chk("R11 cfg page reg 3", r, 8'h00);
    wr(7'd1, 8'hF8); rd(7'd1, r); chk("R2 reserved bits zero", r, 8'h00);
    pwr = 1'b0;
  endtask

  task automatic t_swap();
    logic [23:0] c;
    wr(7'd1, 8'h04); rd(7'd1, r); chk("R2 adaptive enable", r, 8'h04);
    wr_coef(0, 24'hABCDEF);
    dp(3'd0, c); chk("R3 datapath on A", c, 24'h123456);
    rd(7'd8, r); chk("R3 host sees B", r, 8'hAB);
    wr(7'd1, 8'h05); rd(7'd1, r); chk("R4 request pending", r, 8'h05);
    repeat (4) @(negedge clk);
    rd(7'd1, r); chk("R4 no swap without frame", r, 8'h05);
    dp(3'd0, c); chk("R4 datapath unchanged", c, 24'h123456);
    pulse();
    rd(7'd1, r); chk("R4 swapped, request cleared", r, 8'h06);
    dp(3'd0, c); chk("R3 datapath on B", c, 24'hABCDEF);
    rd(7'd8, r); chk("R3 host sees A", r, 8'h12);
  endtask

  task automatic t_same_cycle();
    logic [23:0] c;
    @(negedge clk); addr = 7'd1; wdata = 8'h05; we = 1'b1; frame = 1'b1;
    @(negedge clk); we = 1'b0; frame = 1'b0;
    rd(7'd1, r); chk("R5 request held over", r, 8'h07);
    dp(3'd0, c); chk("R5 no swap on same pulse", c, 24'hABCDEF);
    pulse();
    rd(7'd1, r); chk("R5 swap on next pulse", r, 8'h04);
    dp(3'd0, c); chk("R5 datapath back on A", c, 24'h123456);
  endtask

  task automatic t_off();
    logic [23:0] c;
    wr(7'd1, 8'h05); pulse();
    rd(7'd1, r); chk("R4 swap to B", r, 8'h06);
    wr(7'd1, 8'h00);
    rd(7'd1, r); chk("R7 flag clears on disable", r, 8'h00);
    dp(3'd0, c); chk("R7 datapath on A", c, 24'h123456);
    wr(7'd1, 8'h01);
    rd(7'd1, r); chk("R6 request ignored", r, 8'h00);
    pulse();
    rd(7'd1, r); chk("R6 no swap after pulse", r, 8'h00);
    dp(3'd0, c); chk("R6 datapath stays A", c, 24'h123456);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_page();
        t_gating();
        t_swap();
        t_same_cycle();
        t_off();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule